// File: doc/BRIEF.md
# SMBus Master Serial Clock Generator

This block produces the serial clock of a two-wire SMBus master. It keeps no timer of its own: it counts overflow strobes from one of four shared timers, picked by a 2-bit select. It drives the clock line through an open-drain pull-low control. A nominal bit is one tick low and two ticks high, so the bit rate is the tick rate divided by three. The block also raises single-cycle strobes at the falling edge, where data may change, and at the rising edge, where data is sampled.

The block reads the real line level back through a two-flop synchronizer. This lets a slow slave stretch the low phase and lets a competing master cut the high phase short. The high phase starts only once the line is actually seen high. Each phase always spans at least one full tick period. While the master is disabled, the block can watch the idle line and flag the bus as free once the clock has stayed high for a programmable number of ticks.

Top module: `smb_scl_gen`

## Requirements
- R1: The tick source is picked by `src_sel`: 0 selects `ovf_tick[0]` (timer 0 overflow), 1 selects `ovf_tick[1]` (timer 1 overflow), 2 selects `ovf_tick[2]` (timer 2 high-byte overflow) and 3 selects `ovf_tick[3]` (timer 2 low-byte overflow). Strobes on the other three bits have no effect.
- R2: With `enable` and `free_to_en` both low, ticks are ignored. `scl_pull` stays 0, `bus_free` stays 0 and no strobe fires.
- R3: The line input `scl_in` passes through two flops. In an undisturbed bit, `rise_stb` fires exactly 3 cycles after `scl_pull` falls.
- R4: A low phase entered on a tick releases the line on the next selected tick. A low phase entered any other way (enable, or the line being pulled low by another device) releases the line on the second selected tick. `scl_pull` falls only on a cycle after a selected tick or after a disable.
- R5: After the release, the high phase begins only when the synchronized line is high. Until then no `rise_stb` fires and ticks are not counted.
- R6: The high phase ends, and `scl_pull` is asserted again, on the second selected tick after the high phase began. With no other device on the line, falling strobes are spaced exactly 3 tick periods apart.
- R7: If the synchronized line goes low during the high phase, the block enters the low phase on the next clock edge and fires `fall_stb`. This takes priority over a tick in the same cycle.
- R8: `fall_stb` is a one-cycle pulse in the first cycle that `scl_pull` is 1 in a low phase. `rise_stb` is a one-cycle pulse in the first cycle of the high phase. The two never coincide.
- R9: When `enable` is low, `scl_pull` is 0 from the next cycle onward, the phase counters are cleared and no strobe fires.
- R10: While `enable` is low and `free_to_en` is high, `bus_free` is set after `to_limit` selected ticks (a limit of 0 acts as 1) during which the synchronized line stayed high. It clears on the cycle after the synchronized line is seen low, or after `enable` rises or `free_to_en` falls.
- R11: During reset, `scl_pull`, `fall_stb`, `rise_stb` and `bus_free` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Master clock generation enable |
| free_to_en | input | 1 | Enables bus-free timeout detection while idle |
| src_sel | input | 2 | Tick source select |
| ovf_tick | input | 4 | One-cycle overflow strobes of the four timers |
| to_limit | input | TO_W | Number of high ticks needed to declare the bus free |
| scl_in | input | 1 | Raw clock line level |
| scl_pull | output | 1 | 1 pulls the clock line low |
| fall_stb | output | 1 | Start-of-low-phase strobe |
| rise_stb | output | 1 | Start-of-high-phase strobe |
| bus_free | output | 1 | Bus-free timeout flag |

## Verification
The bench runs the generator on each of the four sources. The sources tick at distinct periods of 7, 11, 13 and 5 cycles, so a wrong select shows up as a wrong bit period, and the release-to-rise delay exposes a missing or extra synchronizer stage. A slave hold during the low phase separates a high phase started by the real line from one started by the tick count. A short pulse from another master during the high phase tests the restart and its priority. An idle-line run with limits 4 and 1, followed by a forced low, covers the timeout count and its clearing. A behavioural reference model is compared with all four outputs on every cycle.

// File: rtl/smb_scl_gen.sv
module smb_scl_gen #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            free_to_en,
  input  logic [1:0]      src_sel,
  input  logic [3:0]      ovf_tick,
  input  logic [TO_W-1:0] to_limit,
  input  logic            scl_in,
  output logic            scl_pull,
  output logic            fall_stb,
  output logic            rise_stb,
  output logic            bus_free
);

  typedef enum logic [1:0] {S_OFF, S_LOW, S_WAIT, S_HIGH} phase_t;

  phase_t          phase;
  logic            cnt;
  logic            need2;
  logic [1:0]      sync;
  logic [TO_W-1:0] to_cnt;
  logic            scl_s;
  logic            tick;

  assign scl_s    = sync[1];
  assign tick     = ovf_tick[src_sel] & (enable | free_to_en);
  assign scl_pull = (phase == S_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], scl_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= S_OFF;
      cnt      <= 1'b0;
      need2    <= 1'b1;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
    end else begin
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      if (!enable) begin
        phase <= S_OFF;
        cnt   <= 1'b0;
        need2 <= 1'b1;
      end else begin
        case (phase)
          S_OFF: begin
            phase    <= S_LOW;
            cnt      <= 1'b0;
            need2    <= 1'b1;
            fall_stb <= 1'b1;
          end
          S_LOW: if (tick) begin
            if (cnt || !need2) begin
              phase <= S_WAIT;
              cnt   <= 1'b0;
            end else begin
              cnt <= 1'b1;
            end
          end
          S_WAIT: if (scl_s) begin
            phase    <= S_HIGH;
            cnt      <= 1'b0;
            rise_stb <= 1'b1;
          end
          S_HIGH: begin
            if (!scl_s) begin
              phase    <= S_LOW;
              cnt      <= 1'b0;
              need2    <= 1'b1;
              fall_stb <= 1'b1;
            end else if (tick) begin
              if (cnt) begin
                phase    <= S_LOW;
                cnt      <= 1'b0;
                need2    <= 1'b0;
                fall_stb <= 1'b1;
              end else begin
                cnt <= 1'b1;
              end
            end
          end
          default: phase <= S_OFF;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_cnt   <= '0;
      bus_free <= 1'b0;
    end else if (enable || !free_to_en || !scl_s) begin
      to_cnt   <= '0;
      bus_free <= 1'b0;
    end else if (tick && !bus_free) begin
      if (({1'b0, to_cnt} + 1'b1) >= {1'b0, to_limit}) bus_free <= 1'b1;
      else                                             to_cnt   <= to_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/smb_scl_gen_chk.sv
module smb_scl_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       free_to_en,
  input logic [1:0] src_sel,
  input logic [3:0] ovf_tick,
  input logic       scl_pull,
  input logic       fall_stb,
  input logic       rise_stb,
  input logic       bus_free
);

  logic tk;
  assign tk = ovf_tick[src_sel];

  p_disable_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_pull);

  p_fall_marks_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> scl_pull);

  p_rise_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> !scl_pull);

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_stb && rise_stb));

  p_low_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && enable && !tk) |=> scl_pull);

  p_release_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_pull) && $past(enable)) |-> $past(tk));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !free_to_en) |=> (!scl_pull && !bus_free));

  p_busy_no_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> !bus_free);

endmodule

bind smb_scl_gen smb_scl_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .free_to_en(free_to_en),
  .src_sel(src_sel), .ovf_tick(ovf_tick), .scl_pull(scl_pull),
  .fall_stb(fall_stb), .rise_stb(rise_stb), .bus_free(bus_free)
);

// File: tb/smb_scl_gen_tb_top.sv
`timescale 1ns/1ps
module smb_scl_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, free_to_en = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic [3:0] ovf_tick = 4'd0;
  logic [7:0] to_limit = 8'd4;
  logic hold_slave = 1'b0, hold_other = 1'b0;
  logic scl_in, scl_pull, fall_stb, rise_stb, bus_free;

  int checks = 0, fails = 0, cyc = 0;
  int per [4] = '{7, 11, 13, 5};
  int fall_cnt = 0, rise_cnt = 0, pull_seen = 0;
  int last_fall = -1, last_per = -1, rel_cyc = 0, rise_delay = -1;
  bit prev_pull = 1'b0;

  // reference model state
  int m_ph = 0, m_cnt = 0, m_need = 2, m_tc = 0;
  bit m_s1 = 1'b1, m_s2 = 1'b1, m_f = 1'b0, m_r = 1'b0, m_bf = 1'b0;

  always #2.5 clk = ~clk;

  assign scl_in = !(scl_pull || hold_slave || hold_other);

  smb_scl_gen #(.TO_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .free_to_en(free_to_en),
    .src_sel(src_sel), .ovf_tick(ovf_tick), .to_limit(to_limit),
    .scl_in(scl_in), .scl_pull(scl_pull), .fall_stb(fall_stb),
    .rise_stb(rise_stb), .bus_free(bus_free)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_need = 2; m_tc = 0;
      m_s1 = 1'b1; m_s2 = 1'b1; m_f = 1'b0; m_r = 1'b0; m_bf = 1'b0;
    end else begin
      bit tk, sv;
      tk = ovf_tick[src_sel] && (enable || free_to_en);
      sv = m_s2;
      m_s2 = m_s1;
      m_s1 = scl_in;
      m_f = 1'b0; m_r = 1'b0;
      if (!enable) begin
        m_ph = 0; m_cnt = 0; m_need = 2;
      end else if (m_ph == 0) begin
        m_ph = 1; m_need = 2; m_cnt = 0; m_f = 1'b1;
      end else if (m_ph == 1) begin
        if (tk) begin
          m_cnt++;
          if (m_cnt >= m_need) begin m_ph = 2; m_cnt = 0; end
        end
      end else if (m_ph == 2) begin
        if (sv) begin m_ph = 3; m_cnt = 0; m_r = 1'b1; end
      end else begin
        if (!sv) begin
          m_ph = 1; m_need = 2; m_cnt = 0; m_f = 1'b1;
        end else if (tk) begin
          m_cnt++;
          if (m_cnt == 2) begin m_ph = 1; m_need = 1; m_cnt = 0; m_f = 1'b1; end
        end
      end
      if (enable || !free_to_en || !sv) begin
        m_tc = 0; m_bf = 1'b0;
      end else if (tk && !m_bf) begin
        if (m_tc + 1 >= int'(to_limit)) m_bf = 1'b1;
        else m_tc++;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(scl_pull == (m_ph == 1), "R4 scl_pull vs model", scl_pull, m_ph == 1);
      chk(fall_stb == m_f, "R8 fall_stb vs model", fall_stb, m_f);
      chk(rise_stb == m_r, "R5 rise_stb vs model", rise_stb, m_r);
      chk(bus_free == m_bf, "R10 bus_free vs model", bus_free, m_bf);
      if (fall_stb) begin
        fall_cnt++;
        if (last_fall >= 0) last_per = cyc - last_fall;
        last_fall = cyc;
      end
      if (rise_stb) begin
        rise_cnt++;
        rise_delay = cyc - rel_cyc;
      end
      if (prev_pull && !scl_pull) rel_cyc = cyc;
      if (scl_pull) pull_seen++;
      prev_pull = scl_pull;
    end
    for (int i = 0; i < 4; i++) ovf_tick[i] = (cyc % per[i] == 0);
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int fc, rc;
    repeat (4) @(negedge clk);
    chk(!scl_pull, "R11 reset scl_pull", scl_pull, 0);
    chk(!fall_stb && !rise_stb, "R11 reset strobes", fall_stb | rise_stb, 0);
    chk(!bus_free, "R11 reset bus_free", bus_free, 0);
    rst_n = 1'b1;

    repeat (60) @(negedge clk);
    chk(pull_seen == 0, "R2 no pull while off", pull_seen, 0);
    chk(fall_cnt == 0 && !bus_free, "R2 no strobe or flag while off", fall_cnt, 0);

    for (int s = 0; s < 4; s++) begin
      src_sel = 2'(s);
      enable = 1'b1;
      last_per = -1;
      repeat (12 * per[s] + 20) @(negedge clk);
      chk(last_per == 3 * per[s], "R1 R6 bit period for source", last_per, 3 * per[s]);
      chk(rise_delay == 3, "R3 release to rise delay", rise_delay, 3);
      enable = 1'b0;
      repeat (3) @(negedge clk);
    end

    src_sel = 2'd0;
    enable = 1'b1;
    for (int i = 0; i < 1000 && !scl_pull; i++) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(!scl_pull, "R9 release after disable", scl_pull, 0);
    fc = fall_cnt;
    repeat (30) @(negedge clk);
    chk(fall_cnt == fc, "R9 no strobe while disabled", fall_cnt, fc);

    src_sel = 2'd1;
    enable = 1'b1;
    for (int i = 0; i < 1000 && !fall_stb; i++) @(negedge clk);
    hold_slave = 1'b1;
    rc = rise_cnt;
    repeat (50) @(negedge clk);
    chk(rise_cnt == rc, "R5 no rise while slave holds", rise_cnt, rc);
    chk(!scl_pull, "R5 master released during hold", scl_pull, 0);
    hold_slave = 1'b0;
    repeat (4) @(negedge clk);
    chk(rise_cnt == rc + 1, "R5 rise after slave release", rise_cnt, rc + 1);

    enable = 1'b0;
    src_sel = 2'd2;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    for (int i = 0; i < 1000 && !rise_stb; i++) @(negedge clk);
    @(negedge clk);
    hold_other = 1'b1;
    fc = fall_cnt;
    repeat (2) @(negedge clk);
    hold_other = 1'b0;
    repeat (4) @(negedge clk);
    chk(fall_cnt == fc + 1, "R7 restart on early low", fall_cnt, fc + 1);
    chk(scl_pull, "R7 low phase restarted", scl_pull, 1);

    enable = 1'b0;
    free_to_en = 1'b1;
    src_sel = 2'd3;
    to_limit = 8'd4;
    repeat (2) @(negedge clk);
    chk(!bus_free, "R10 not free yet", bus_free, 0);
    repeat (30) @(negedge clk);
    chk(bus_free, "R10 free after limit", bus_free, 1);
    hold_other = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bus_free, "R10 cleared by low line", bus_free, 0);
    hold_other = 1'b0;
    to_limit = 8'd1;
    repeat (15) @(negedge clk);
    chk(bus_free, "R10 limit of one", bus_free, 1);
    free_to_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(!bus_free, "R2 flag dropped when detection off", bus_free, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule